// File: doc/BRIEF.md
# Coherent Cache Line Agent

This block is the per-core end of a directory-based coherence scheme. It holds a small direct-mapped cache in which each line carries a valid flag and a modified flag. A set modified flag means this core is the only holder of the line and that memory is out of date. Core reads and writes finish locally whenever those flags allow it. In every other case the agent sends one request to the directory, holds the core in a stall, and completes the access in the cycle the grant arrives.

The directory can also send two kinds of message to the agent: an invalidate, which removes the local copy, and a fetch, which asks the owner to return its data and give up the modified state. The agent answers each message one cycle later with an acknowledgement. That acknowledgement carries the core number, the address and the line contents, plus a flag that tells the directory whether memory must be updated.

A line holds WORDS words of DATA_W bits, and word w sits at bits [w*DATA_W +: DATA_W]. An address is {tag, index, word offset}, with the most significant bits on the left.

Top module: `coh_line_agent`

## Requirements
- R1: After reset, every line is invalid, `cpu_stall`, `dir_req_valid` and `ack_valid` are low, and the first read of any address produces a read-miss request.
- R2: A read whose line is valid and whose tag matches returns the word on `cpu_rdata` in the same cycle, with `cpu_stall` low and no directory request.
- R3: A read that does not hit raises `dir_req_valid` in that cycle, with `dir_req_kind` = 1 (read miss) and the full address. In the grant cycle, `cpu_rdata` shows the addressed word of `gnt_line`, and the line is left valid and unmodified.
- R4: A write that hits a line with its modified flag set updates only the addressed word, with no directory request and no stall.
- R5: A write that hits a valid but unmodified line requests with `dir_req_kind` = 3 (upgrade). On grant, the addressed word takes the write data, the other words keep their cached values, and the line becomes modified.
- R6: A write that misses requests with `dir_req_kind` = 2 (write miss). On grant, the line is loaded from `gnt_line` with the addressed word replaced by the write data, and it becomes modified.
- R7: A message with `snp_kind` = 0 (invalidate) that matches a held line clears that line's valid and modified flags. The next access to that line misses.
- R8: A message with `snp_kind` = 1 (fetch) that matches a held line returns the line on `ack_data`. It sets `ack_wb` only if the line was modified, clears the modified flag and keeps the line valid.
- R9: Every directory message is acknowledged exactly one cycle later: `ack_valid` is high and `ack_kind`, `ack_addr` and `ack_core` (= CORE_ID) are set. A message whose tag does not match changes no line state and returns `ack_data` = 0.
- R10: From the cycle a request is issued until the cycle of the grant, `cpu_stall` stays high and no further request is issued.
- R11: In a cycle with `snp_valid` high, a core access is not accepted: `cpu_stall` is high and no request is issued. The access proceeds in the next free cycle.
- R12: An invalidate that matches the line of a pending upgrade turns it into a write miss. The grant then fills the line from `gnt_line` rather than from the discarded cached copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Core access request, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address {tag, index, offset} |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid when accepted |
| cpu_stall | output | 1 | Access not accepted this cycle |
| dir_req_valid | output | 1 | Request to the directory |
| dir_req_kind | output | 2 | 1 read miss, 2 write miss, 3 upgrade |
| dir_req_addr | output | ADDR_W | Request address |
| dir_req_core | output | CORE_W | Requesting core number |
| gnt_valid | input | 1 | Directory grant for the pending request |
| gnt_line | input | WORDS*DATA_W | Line data delivered with the grant |
| snp_valid | input | 1 | Directory message valid |
| snp_kind | input | 1 | 0 invalidate, 1 fetch |
| snp_addr | input | ADDR_W | Message address |
| ack_valid | output | 1 | Acknowledgement valid |
| ack_kind | output | 1 | Kind of the message acknowledged |
| ack_addr | output | ADDR_W | Address acknowledged |
| ack_core | output | CORE_W | This core's number |
| ack_data | output | WORDS*DATA_W | Line contents at the time of the message |
| ack_wb | output | 1 | Memory must take ack_data |

## Verification
A directory message and a core access can arrive in the same cycle. So can an invalidate and this agent's own outstanding upgrade for the same line. The bench provokes the first case by raising a fetch alongside a read that would hit, and judges it by the stall and the absence of a request in that cycle, followed by the correct read one cycle later. For the second case, the bench sends an invalidate while an upgrade waits. It then grants with new line data and reads the word the core did not write: that word must come from the grant, not from the cache.

// File: rtl/coh_agent_pkg.sv
`timescale 1ns/1ps
package coh_agent_pkg;
  typedef enum logic [1:0] {
    REQ_NONE    = 2'd0,
    REQ_RD_MISS = 2'd1,
    REQ_WR_MISS = 2'd2,
    REQ_UPGRADE = 2'd3
  } req_kind_e;

  typedef enum logic {
    SNP_INV   = 1'b0,
    SNP_FETCH = 1'b1
  } snp_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } agent_state_e;
endpackage

// File: rtl/coh_line_store.sv
`timescale 1ns/1ps
module coh_line_store #(
  parameter int LINES  = 4,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16,
  parameter int WORDS  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(LINES)-1:0] c_idx,
  output logic                     c_valid,
  output logic                     c_dirty,
  output logic [TAG_W-1:0]         c_tag,
  output logic [WORDS*DATA_W-1:0]  c_line,
  input  logic [$clog2(LINES)-1:0] s_idx,
  output logic                     s_valid,
  output logic                     s_dirty,
  output logic [TAG_W-1:0]         s_tag,
  output logic [WORDS*DATA_W-1:0]  s_line,
  input  logic [$clog2(LINES)-1:0] p_idx,
  output logic [WORDS*DATA_W-1:0]  p_line,
  input  logic                     fill_en,
  input  logic [TAG_W-1:0]         fill_tag,
  input  logic                     fill_dirty,
  input  logic [WORDS*DATA_W-1:0]  fill_line,
  input  logic                     wr_en,
  input  logic [$clog2(WORDS)-1:0] wr_off,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     clr_en,
  input  logic                     clr_inv
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int LINE_W = WORDS * DATA_W;

  logic [LINES-1:0]  v_all, d_all;
  logic [TAG_W-1:0]  t_all [LINES];
  logic [LINE_W-1:0] l_all [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              v_q, v_d, d_q, d_d;
    logic [TAG_W-1:0]  t_q, t_d;
    logic [LINE_W-1:0] l_q, l_d;
    logic              hit_fill, hit_wr, hit_clr;

    assign hit_fill = fill_en && (p_idx == IDX_W'(i));
    assign hit_wr   = wr_en   && (c_idx == IDX_W'(i));
    assign hit_clr  = clr_en  && (s_idx == IDX_W'(i));

    // fill and write first, directory message applied last
    always_comb begin
      v_d = v_q;
      d_d = d_q;
      t_d = t_q;
      l_d = l_q;
      if (hit_fill) begin
        v_d = 1'b1;
        d_d = fill_dirty;
        t_d = fill_tag;
        l_d = fill_line;
      end
      if (hit_wr) begin
        l_d[wr_off*DATA_W +: DATA_W] = wr_data;
        d_d = 1'b1;
      end
      if (hit_clr) begin
        d_d = 1'b0;
        if (clr_inv) v_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else begin
        v_q <= v_d;
        d_q <= d_d;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_fill || hit_wr) begin
        t_q <= t_d;
        l_q <= l_d;
      end
    end

    assign v_all[i] = v_q;
    assign d_all[i] = d_q;
    assign t_all[i] = t_q;
    assign l_all[i] = l_q;
  end

  assign c_valid = v_all[c_idx];
  assign c_dirty = d_all[c_idx];
  assign c_tag   = t_all[c_idx];
  assign c_line  = l_all[c_idx];
  assign s_valid = v_all[s_idx];
  assign s_dirty = d_all[s_idx];
  assign s_tag   = t_all[s_idx];
  assign s_line  = l_all[s_idx];
  assign p_line  = l_all[p_idx];

  AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (d_all & ~v_all) == '0); // R6
  AST_INV_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_inv) |=> !v_all[$past(s_idx)]); // R7
  AST_FETCH_CLEANS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !clr_inv) |=> !d_all[$past(s_idx)]); // R8
endmodule

// File: rtl/coh_snoop_resp.sv
`timescale 1ns/1ps
module coh_snoop_resp #(
  parameter int ADDR_W  = 8,
  parameter int TAG_W   = 5,
  parameter int LINE_W  = 32,
  parameter int CORE_W  = 2,
  parameter int CORE_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic              snp_kind,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              s_valid,
  input  logic              s_dirty,
  input  logic [TAG_W-1:0]  s_tag,
  input  logic [LINE_W-1:0] s_line,
  output logic              clr_en,
  output logic              clr_inv,
  output logic              ack_valid,
  output logic              ack_kind,
  output logic [ADDR_W-1:0] ack_addr,
  output logic [CORE_W-1:0] ack_core,
  output logic [LINE_W-1:0] ack_data,
  output logic              ack_wb
);
  import coh_agent_pkg::*;

  logic              match;
  logic              av_q, av_d;
  logic              ak_q;
  logic [ADDR_W-1:0] aa_q;
  logic [LINE_W-1:0] ad_q, ad_d;
  logic              wb_q, wb_d;

  assign match   = snp_valid && s_valid && (s_tag == snp_addr[ADDR_W-1 -: TAG_W]);
  assign clr_en  = match;
  assign clr_inv = (snp_kind_e'(snp_kind) == SNP_INV);

  always_comb begin
    av_d = snp_valid;
    ad_d = match ? s_line : '0;
    wb_d = match && !clr_inv && s_dirty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) av_q <= 1'b0;
    else        av_q <= av_d;
  end

  always_ff @(posedge clk) begin
    if (snp_valid) begin
      ak_q <= snp_kind;
      aa_q <= snp_addr;
      ad_q <= ad_d;
      wb_q <= wb_d;
    end
  end

  assign ack_valid = av_q;
  assign ack_kind  = ak_q;
  assign ack_addr  = aa_q;
  assign ack_core  = CORE_W'(CORE_ID);
  assign ack_data  = ad_q;
  assign ack_wb    = wb_q && av_q;

  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> (ack_valid && ack_addr == $past(snp_addr))); // R9
  AST_ACK_ONLY_ON_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |=> !ack_valid); // R9
endmodule

// File: rtl/coh_req_ctrl.sv
`timescale 1ns/1ps
module coh_req_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int WORDS  = 2,
  parameter int LINES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [DATA_W-1:0]         cpu_wdata,
  output logic [DATA_W-1:0]         cpu_rdata,
  output logic                      cpu_stall,
  output logic                      dir_req_valid,
  output logic [1:0]                dir_req_kind,
  input  logic                      gnt_valid,
  input  logic [WORDS*DATA_W-1:0]   gnt_line,
  input  logic                      snp_valid,
  input  logic                      snp_kind,
  input  logic [ADDR_W-1:0]         snp_addr,
  input  logic                      c_valid,
  input  logic                      c_dirty,
  input  logic [ADDR_W-$clog2(LINES)-$clog2(WORDS)-1:0] c_tag,
  input  logic [WORDS*DATA_W-1:0]   c_line,
  input  logic [WORDS*DATA_W-1:0]   p_line,
  output logic [$clog2(LINES)-1:0]  p_idx,
  output logic                      fill_en,
  output logic [ADDR_W-$clog2(LINES)-$clog2(WORDS)-1:0] fill_tag,
  output logic                      fill_dirty,
  output logic [WORDS*DATA_W-1:0]   fill_line,
  output logic                      wr_en
);
  import coh_agent_pkg::*;

  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  agent_state_e      st_q, st_d;
  req_kind_e         pk_q, pk_d, new_kind;
  logic [ADDR_W-1:0] pa_q;
  logic [DATA_W-1:0] pw_q;
  logic              pwe_q;
  logic              hit, permit, idle_go, in_wait, inv_on_pend;
  logic [OFF_W-1:0]  c_off, p_off;

  assign c_off   = cpu_addr[OFF_W-1:0];
  assign p_off   = pa_q[OFF_W-1:0];
  assign p_idx   = pa_q[OFF_W +: IDX_W];
  assign in_wait = (st_q == ST_WAIT);

  assign hit     = c_valid && (c_tag == cpu_addr[ADDR_W-1 -: TAG_W]);
  assign permit  = hit && (!cpu_we || c_dirty);
  assign idle_go = !in_wait && cpu_req && !snp_valid;

  always_comb begin
    if (!cpu_we)  new_kind = REQ_RD_MISS;
    else if (hit) new_kind = REQ_UPGRADE;
    else          new_kind = REQ_WR_MISS;
  end

  assign dir_req_valid = idle_go && !permit;
  assign dir_req_kind  = dir_req_valid ? 2'(new_kind) : 2'(REQ_NONE);
  assign wr_en         = idle_go && permit && cpu_we;
  assign cpu_stall     = in_wait ? !gnt_valid : (cpu_req && (snp_valid || !permit));

  assign fill_en    = in_wait && gnt_valid;
  assign fill_tag   = pa_q[ADDR_W-1 -: TAG_W];
  assign fill_dirty = pwe_q;

  always_comb begin
    fill_line = (pk_q == REQ_UPGRADE) ? p_line : gnt_line;
    if (pwe_q) fill_line[p_off*DATA_W +: DATA_W] = pw_q;
  end

  always_comb begin
    if (in_wait) cpu_rdata = gnt_line[p_off*DATA_W +: DATA_W];
    else         cpu_rdata = c_line[c_off*DATA_W +: DATA_W];
  end

  assign inv_on_pend = in_wait && snp_valid && (snp_kind_e'(snp_kind) == SNP_INV)
                    && (snp_addr[ADDR_W-1:OFF_W] == pa_q[ADDR_W-1:OFF_W]);

  always_comb begin
    st_d = st_q;
    pk_d = pk_q;
    if (dir_req_valid) begin
      st_d = ST_WAIT;
      pk_d = new_kind;
    end else if (fill_en) begin
      st_d = ST_IDLE;
      pk_d = REQ_NONE;
    end else if (inv_on_pend && pk_q == REQ_UPGRADE) begin
      pk_d = REQ_WR_MISS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      pk_q <= REQ_NONE;
    end else begin
      st_q <= st_d;
      pk_q <= pk_d;
    end
  end

  always_ff @(posedge clk) begin
    if (dir_req_valid) begin
      pa_q  <= cpu_addr;
      pw_q  <= cpu_wdata;
      pwe_q <= cpu_we;
    end
  end

  AST_REQ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    dir_req_valid |-> cpu_stall); // R10
  AST_WAIT_UNTIL_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    dir_req_valid |=> (cpu_stall || gnt_valid)); // R10
  AST_NO_SECOND_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dir_req_valid |=> !dir_req_valid); // R10
  AST_MSG_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !dir_req_valid && !wr_en); // R11
endmodule

// File: rtl/coh_line_agent.sv
`timescale 1ns/1ps
module coh_line_agent #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int WORDS   = 2,
  parameter int LINES   = 4,
  parameter int CORE_W  = 2,
  parameter int CORE_ID = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    cpu_stall,
  output logic                    dir_req_valid,
  output logic [1:0]              dir_req_kind,
  output logic [ADDR_W-1:0]       dir_req_addr,
  output logic [CORE_W-1:0]       dir_req_core,
  input  logic                    gnt_valid,
  input  logic [WORDS*DATA_W-1:0] gnt_line,
  input  logic                    snp_valid,
  input  logic                    snp_kind,
  input  logic [ADDR_W-1:0]       snp_addr,
  output logic                    ack_valid,
  output logic                    ack_kind,
  output logic [ADDR_W-1:0]       ack_addr,
  output logic [CORE_W-1:0]       ack_core,
  output logic [WORDS*DATA_W-1:0] ack_data,
  output logic                    ack_wb
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = WORDS * DATA_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              c_valid, c_dirty, s_valid, s_dirty;
  logic [TAG_W-1:0]  c_tag, s_tag, fill_tag;
  logic [LINE_W-1:0] c_line, s_line, p_line, fill_line;
  logic [IDX_W-1:0]  p_idx;
  logic              fill_en, fill_dirty, wr_en, clr_en, clr_inv;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign dir_req_addr = cpu_addr;
  assign dir_req_core = CORE_W'(CORE_ID);

  coh_req_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES)) ctrl_i (
    .clk(clk), .rst_n(rst_int_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .dir_req_valid(dir_req_valid), .dir_req_kind(dir_req_kind),
    .gnt_valid(gnt_valid), .gnt_line(gnt_line),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
    .c_valid(c_valid), .c_dirty(c_dirty), .c_tag(c_tag), .c_line(c_line),
    .p_line(p_line), .p_idx(p_idx),
    .fill_en(fill_en), .fill_tag(fill_tag), .fill_dirty(fill_dirty), .fill_line(fill_line),
    .wr_en(wr_en)
  );

  coh_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .WORDS(WORDS)) store_i (
    .clk(clk), .rst_n(rst_int_n),
    .c_idx(cpu_addr[OFF_W +: IDX_W]), .c_valid(c_valid), .c_dirty(c_dirty),
    .c_tag(c_tag), .c_line(c_line),
    .s_idx(snp_addr[OFF_W +: IDX_W]), .s_valid(s_valid), .s_dirty(s_dirty),
    .s_tag(s_tag), .s_line(s_line),
    .p_idx(p_idx), .p_line(p_line),
    .fill_en(fill_en), .fill_tag(fill_tag), .fill_dirty(fill_dirty), .fill_line(fill_line),
    .wr_en(wr_en), .wr_off(cpu_addr[OFF_W-1:0]), .wr_data(cpu_wdata),
    .clr_en(clr_en), .clr_inv(clr_inv)
  );

  coh_snoop_resp #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .LINE_W(LINE_W),
                   .CORE_W(CORE_W), .CORE_ID(CORE_ID)) resp_i (
    .clk(clk), .rst_n(rst_int_n),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
    .s_valid(s_valid), .s_dirty(s_dirty), .s_tag(s_tag), .s_line(s_line),
    .clr_en(clr_en), .clr_inv(clr_inv),
    .ack_valid(ack_valid), .ack_kind(ack_kind), .ack_addr(ack_addr), .ack_core(ack_core),
    .ack_data(ack_data), .ack_wb(ack_wb)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> !ack_valid); // R1
endmodule

// File: tb/coh_line_agent_tb_top.sv
`timescale 1ns/1ps
module coh_line_agent_tb_top;
  localparam int AW = 8, DW = 16, LW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req, cpu_we, gnt_valid, snp_valid, snp_kind;
  logic [AW-1:0] cpu_addr, snp_addr;
  logic [DW-1:0] cpu_wdata;
  logic [LW-1:0] gnt_line;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_stall, dir_req_valid, ack_valid, ack_kind, ack_wb;
  logic [1:0]    dir_req_kind, dir_req_core, ack_core;
  logic [AW-1:0] dir_req_addr, ack_addr;
  logic [LW-1:0] ack_data;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  coh_line_agent #(.ADDR_W(AW), .DATA_W(DW), .WORDS(2), .LINES(4),
                   .CORE_W(2), .CORE_ID(3)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .dir_req_valid(dir_req_valid), .dir_req_kind(dir_req_kind),
    .dir_req_addr(dir_req_addr), .dir_req_core(dir_req_core),
    .gnt_valid(gnt_valid), .gnt_line(gnt_line),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
    .ack_valid(ack_valid), .ack_kind(ack_kind), .ack_addr(ack_addr), .ack_core(ack_core),
    .ack_data(ack_data), .ack_wb(ack_wb)
  );

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [1:0]    kind;
    logic [LW-1:0] gnt;
    logic [DW-1:0] rdata;
  } vec_t;

  // addr = {tag[4:0], idx[1:0], off}; kind 0 none, 1 rd miss, 2 wr miss, 3 upgrade
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h08, 16'h0000, 2'd1, 32'hB0B0_A0A0, 16'hA0A0},
    '{1'b0, 8'h09, 16'h0000, 2'd0, 32'h0,         16'hB0B0},
    '{1'b1, 8'h08, 16'h1234, 2'd3, 32'h0,         16'h0},
    '{1'b0, 8'h08, 16'h0000, 2'd0, 32'h0,         16'h1234},
    '{1'b1, 8'h09, 16'h5678, 2'd0, 32'h0,         16'h0},
    '{1'b0, 8'h09, 16'h0000, 2'd0, 32'h0,         16'h5678},
    '{1'b1, 8'h13, 16'h9ABC, 2'd2, 32'hC0C0_D0D0, 16'h0},
    '{1'b0, 8'h12, 16'h0000, 2'd0, 32'h0,         16'hD0D0},
    '{1'b0, 8'h13, 16'h0000, 2'd0, 32'h0,         16'h9ABC},
    '{1'b0, 8'h1A, 16'h0000, 2'd1, 32'hEEEE_FFFF, 16'hFFFF},
    '{1'b0, 8'h12, 16'h0000, 2'd1, 32'h5555_6666, 16'h6666},
    '{1'b0, 8'h13, 16'h0000, 2'd0, 32'h0,         16'h5555}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [1:0] kind, input logic [LW-1:0] gl,
                        input logic [DW-1:0] rd, input string req);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    chk(dir_req_kind == kind && dir_req_valid == (kind != 2'd0), req, "request kind",
        {30'd0, dir_req_kind}, {30'd0, kind});
    if (kind != 2'd0) begin
      chk(cpu_stall && dir_req_addr == a, "R10", "stall at issue", {31'd0, cpu_stall}, 32'd1);
      @(negedge clk); #1;
      chk(cpu_stall && !dir_req_valid, "R10", "stall while waiting",
          {30'd0, cpu_stall, dir_req_valid}, 32'd2);
      @(negedge clk);
      gnt_valid = 1'b1; gnt_line = gl;
      #1;
      chk(!cpu_stall, req, "stall at grant", {31'd0, cpu_stall}, 32'd0);
    end else begin
      chk(!cpu_stall, req, "local stall", {31'd0, cpu_stall}, 32'd0);
    end
    if (!we) chk(cpu_rdata == rd, req, "read data", {16'd0, cpu_rdata}, {16'd0, rd});
    @(negedge clk);
    cpu_req = 1'b0; gnt_valid = 1'b0;
  endtask

  task automatic message(input logic k, input logic [AW-1:0] a, input bit chk_data,
                         input logic [LW-1:0] dat, input logic wb, input string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_kind = k; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    chk(ack_valid && ack_kind == k && ack_addr == a && ack_core == 2'd3, "R9",
        "ack fields", {ack_valid, ack_kind, ack_core, 21'd0, ack_addr},
        {1'b1, k, 2'd3, 21'd0, a});
    if (chk_data) begin
      chk(ack_data == dat, req, "ack data", ack_data, dat);
      chk(ack_wb == wb, req, "ack wb", {31'd0, ack_wb}, {31'd0, wb});
    end
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    gnt_valid = 1'b0; gnt_line = '0; snp_valid = 1'b0; snp_kind = 1'b0; snp_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!cpu_stall && !dir_req_valid && !ack_valid, "R1", "idle after reset",
        {29'd0, cpu_stall, dir_req_valid, ack_valid}, 32'd0);
    chk(dir_req_core == 2'd3, "R3", "request core", {30'd0, dir_req_core}, 32'd3);

    // R1 first read misses, then table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++)
      access(VEC[i].we, VEC[i].addr, VEC[i].wdata, VEC[i].kind, VEC[i].gnt, VEC[i].rdata,
             (i == 0) ? "R1" : (VEC[i].kind == 2'd1) ? "R3" : (VEC[i].kind == 2'd2) ? "R6" :
             (VEC[i].kind == 2'd3) ? "R5" : VEC[i].we ? "R4" : "R2");

    // R8 fetch on modified line 0 (tag 1 holds 5678_1234)
    message(1'b1, 8'h09, 1'b1, 32'h5678_1234, 1'b1, "R8");
    access(1'b1, 8'h08, 16'h4321, 2'd3, 32'hFFFF_FFFF, 16'h0, "R8");
    access(1'b0, 8'h09, 16'h0, 2'd0, 32'h0, 16'h5678, "R5");
    access(1'b0, 8'h08, 16'h0, 2'd0, 32'h0, 16'h4321, "R5");
    // R7 invalidate then miss
    message(1'b0, 8'h08, 1'b0, 32'h0, 1'b0, "R7");
    access(1'b0, 8'h09, 16'h0, 2'd1, 32'h7777_8888, 16'h7777, "R7");
    // R9 tag mismatch leaves line 1 alone
    message(1'b0, 8'h3A, 1'b1, 32'h0, 1'b0, "R9");
    access(1'b0, 8'h12, 16'h0, 2'd0, 32'h0, 16'h6666, "R9");
    // R8 fetch on clean line: no writeback
    message(1'b1, 8'h12, 1'b1, 32'h5555_6666, 1'b0, "R8");

    // R11 message and core hit in the same cycle
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h13;
    snp_valid = 1'b1; snp_kind = 1'b1; snp_addr = 8'h08;
    #1;
    chk(cpu_stall && !dir_req_valid, "R11", "core held during message",
        {30'd0, cpu_stall, dir_req_valid}, 32'd2);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    chk(!cpu_stall && cpu_rdata == 16'h5555, "R11", "access after message",
        {15'd0, cpu_stall, cpu_rdata}, 32'h0000_5555);
    @(negedge clk);
    cpu_req = 1'b0;

    // R12 invalidate hits a pending upgrade
    access(1'b0, 8'h22, 16'h0, 2'd1, 32'h2222_1111, 16'h1111, "R12");
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h22; cpu_wdata = 16'hAAAA;
    #1;
    chk(dir_req_valid && dir_req_kind == 2'd3, "R12", "upgrade issued",
        {30'd0, dir_req_kind}, 32'd3);
    @(negedge clk);
    snp_valid = 1'b1; snp_kind = 1'b0; snp_addr = 8'h23;
    #1;
    chk(cpu_stall, "R10", "stall across message", {31'd0, cpu_stall}, 32'd1);
    @(negedge clk);
    snp_valid = 1'b0; gnt_valid = 1'b1; gnt_line = 32'h3333_4444;
    #1;
    chk(ack_valid && ack_addr == 8'h23, "R9", "ack during wait", {23'd0, ack_valid, ack_addr},
        {23'd0, 1'b1, 8'h23});
    chk(!cpu_stall, "R12", "grant releases core", {31'd0, cpu_stall}, 32'd0);
    @(negedge clk);
    cpu_req = 1'b0; gnt_valid = 1'b0;
    access(1'b0, 8'h23, 16'h0, 2'd0, 32'h0, 16'h3333, "R12");
    access(1'b0, 8'h22, 16'h0, 2'd0, 32'h0, 16'hAAAA, "R12");
    access(1'b1, 8'h23, 16'hBEEF, 2'd0, 32'h0, 16'h0, "R6");

    // R1 reset again clears all lines
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    access(1'b0, 8'h22, 16'h0, 2'd1, 32'h0000_0001, 16'h0001, "R1");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule